// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes zero-address commands against a small last-in-first-out stack kept in an internal register file. A stack pointer register always addresses the current top element. A separate flag marks the empty state, which stands for a pointer value of minus one. Push, pop, add and subtract take no operand addresses. Each one works on the top of the stack and moves the pointer by its own fixed amount.

A command is presented with `cmdValid` high for one clock cycle. Every command completes in that cycle. All outputs reflect the command from the cycle after the sampling edge. A pop returns the removed value with a one-cycle valid strobe. `topData` always shows the live top entry. A command that would overrun either end of the stack is refused and leaves the stack untouched. It raises a one-cycle error flag instead. Arithmetic wraps modulo 2^W and no carry is produced.

Top module: `stk_exec`

## Requirements
- R1: After reset the stack is empty, `topData` reads 0, and `popValid`, `ovfErr` and `udfErr` are all low.
- R2: A push (cmdOp = 0) on a stack that is not full places `cmdData` on top; `topData` shows it in the following cycle.
- R3: A pop (cmdOp = 1) on a non-empty stack returns the top value on `popData` with `popValid` high for exactly one cycle; the entry beneath becomes the top, or `topData` reads 0 if the stack becomes empty.
- R4: An add (cmdOp = 2) with at least two entries replaces the top two entries with their sum modulo 2^16, so the depth drops by one.
- R5: A subtract (cmdOp = 3) with at least two entries replaces the top two entries with the old top minus the entry beneath it, modulo 2^16.
- R6: A push when 16 entries are held raises `ovfErr` for one cycle; contents and pointer stay unchanged.
- R7: A pop on an empty stack raises `udfErr` for one cycle, leaves `popValid` low and changes nothing.
- R8: An add or subtract with fewer than two entries raises `udfErr` for one cycle and changes nothing.
- R9: With `cmdValid` low the stack, `topData` and all strobes hold still (strobes low).
- R10: Entries pushed to full depth come back by pops in exactly reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 2 | 0 push, 1 pop, 2 add, 3 subtract |
| cmdData | input | 16 | Value for push |
| popData | output | 16 | Value removed by the last pop |
| popValid | output | 1 | One-cycle strobe qualifying popData |
| topData | output | 16 | Current top entry, 0 when empty |
| ovfErr | output | 1 | One-cycle strobe: push refused on full stack |
| udfErr | output | 1 | One-cycle strobe: command refused for too few entries |

## Verification
The assertions assume that `cmdOp` and `cmdValid` are known on every sampled edge after reset. They also assume that a push carries a defined `cmdData`, because the sum and difference checks follow stored values back to their source. The stimulus drives every input on the falling edge from bench tasks and never leaves them undefined. The random mix leans toward pushes and pops so that the stack repeatedly reaches both the full and the empty boundary. Directed sequences then force the refused commands and the wrap-around sums.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_SUB  = 2'd3
  } stk_op_e;

  typedef enum logic {
    WR_PUSH = 1'b0,
    WR_ALU  = 1'b1
  } stk_wrsel_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic       wrEn;
    stk_wrsel_e wrSel;
    logic       aluSub;
    logic       popLatch;
  } stk_strb_t;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  output stk_strb_t     strb,
  output logic [AW-1:0] topPtr,
  output logic [AW-1:0] secPtr,
  output logic [AW-1:0] wrAddr,
  output logic          stkEmpty,
  output logic          popValid,
  output logic          ovfErr,
  output logic          udfErr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] ONE  = AW'(1);

  stk_op_e op;
  logic    isFull;
  logic    hasTwo;
  logic    doPush, doPop, doArith;
  logic    rejOvf, rejUdf;

  assign op      = stk_op_e'(cmdOp);
  assign isFull  = !stkEmpty && (topPtr == LAST);
  assign hasTwo  = !stkEmpty && (topPtr != '0);
  assign secPtr  = topPtr - ONE;

  always_comb begin
    doPush  = 1'b0;
    doPop   = 1'b0;
    doArith = 1'b0;
    rejOvf  = 1'b0;
    rejUdf  = 1'b0;
    if (cmdValid) begin
      unique case (op)
        OP_PUSH: if (isFull)   rejOvf = 1'b1; else doPush  = 1'b1;
        OP_POP:  if (stkEmpty) rejUdf = 1'b1; else doPop   = 1'b1;
        OP_ADD, OP_SUB:
                 if (!hasTwo)  rejUdf = 1'b1; else doArith = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrEn     = doPush || doArith;
    strb.wrSel    = doArith ? WR_ALU : WR_PUSH;
    strb.aluSub   = (op == OP_SUB);
    strb.popLatch = doPop;
    if (doPush) wrAddr = stkEmpty ? '0 : topPtr + ONE;
    else        wrAddr = secPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topPtr   <= '0;
      stkEmpty <= 1'b1;
      popValid <= 1'b0;
      ovfErr   <= 1'b0;
      udfErr   <= 1'b0;
    end else begin
      popValid <= doPop;
      ovfErr   <= rejOvf;
      udfErr   <= rejUdf;
      if (doPush) begin
        topPtr   <= stkEmpty ? '0 : topPtr + ONE;
        stkEmpty <= 1'b0;
      end else if (doPop) begin
        if (topPtr == '0) stkEmpty <= 1'b1;
        else              topPtr   <= topPtr - ONE;
      end else if (doArith) begin
        topPtr <= topPtr - ONE;
      end
    end
  end

  // R6
  full_push_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0 && !stkEmpty && topPtr == LAST)
      |=> (ovfErr && $stable(topPtr) && !stkEmpty));

  // R7
  empty_pop_udf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1 && stkEmpty)
      |=> (udfErr && !popValid && stkEmpty));

  // R8
  short_arith_udf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp[1] && (stkEmpty || topPtr == '0))
      |=> (udfErr && $stable(topPtr) && $stable(stkEmpty)));

  // R2
  push_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0 && !stkEmpty && topPtr != LAST)
      |=> (topPtr == $past(topPtr) + ONE && !stkEmpty));

  // R4
  arith_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp[1] && !stkEmpty && topPtr != '0)
      |=> (topPtr == $past(topPtr) - ONE));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> ($stable(topPtr) && $stable(stkEmpty) && !popValid && !ovfErr && !udfErr));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({popValid, ovfErr, udfErr}));
endmodule

// File: rtl/stk_dpath.sv
module stk_dpath
  import stk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  stk_strb_t     strb,
  input  logic [AW-1:0] topPtr,
  input  logic [AW-1:0] secPtr,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  pushData,
  output logic [W-1:0]  rdTop,
  output logic [W-1:0]  popData
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdSec;
  logic [W-1:0] aluRes;
  logic [W-1:0] wrVal;

  assign rdTop = mem[topPtr];
  assign rdSec = mem[secPtr];

  // old top minus the entry beneath for subtract
  always_comb aluRes = strb.aluSub ? (rdTop - rdSec) : (rdSec + rdTop);
  always_comb wrVal  = (strb.wrSel == WR_ALU) ? aluRes : pushData;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrAddr] <= wrVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              popData <= '0;
    else if (strb.popLatch) popData <= rdTop;
  end

  // R3
  pop_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.popLatch |=> (popData == $past(rdTop)));

  // R2
  push_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrSel == WR_PUSH) |=> (mem[$past(wrAddr)] == $past(pushData)));
endmodule

// File: rtl/stk_exec.sv
module stk_exec
  import stk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [1:0]   cmdOp,
  input  logic [W-1:0] cmdData,
  output logic [W-1:0] popData,
  output logic         popValid,
  output logic [W-1:0] topData,
  output logic         ovfErr,
  output logic         udfErr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stk_strb_t     strb;
  logic [AW-1:0] topPtr, secPtr, wrAddr;
  logic          stkEmpty;
  logic [W-1:0]  rdTop;

  stk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .strb(strb), .topPtr(topPtr), .secPtr(secPtr), .wrAddr(wrAddr),
    .stkEmpty(stkEmpty), .popValid(popValid), .ovfErr(ovfErr), .udfErr(udfErr)
  );

  stk_dpath #(.DEPTH(DEPTH), .W(W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .topPtr(topPtr), .secPtr(secPtr),
    .wrAddr(wrAddr), .pushData(cmdData), .rdTop(rdTop), .popData(popData)
  );

  assign topData = stkEmpty ? '0 : rdTop;

  // R1
  empty_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stkEmpty |-> (topData == '0));
endmodule

// File: tb/stk_exec_tb.sv
module stk_exec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [15:0] cmdData = 16'd0;
  logic [15:0] popData, topData;
  logic        popValid, ovfErr, udfErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] model [DEPTH];
  int          cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_exec u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .popData(popData), .popValid(popValid), .topData(topData),
    .ovfErr(ovfErr), .udfErr(udfErr)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expTop();
    return (cnt == 0) ? 16'd0 : model[cnt-1];
  endfunction

  function automatic logic [15:0] expArith(input logic sub, input logic [15:0] t, input logic [15:0] s);
    return sub ? (t - s) : (s + t);
  endfunction

  // issue one command at a falling edge, check outputs at the next falling edge
  task automatic runCmd(input logic v, input logic [1:0] op, input logic [15:0] d);
    string    req;
    logic     eOvf = 1'b0, eUdf = 1'b0, ePv = 1'b0;
    logic [15:0] ePop = 16'd0;
    if (!v) req = "R9";
    else begin
      case (op)
        2'd0: if (cnt == DEPTH) begin req = "R6"; eOvf = 1'b1; end
              else begin req = "R2"; model[cnt] = d; cnt++; end
        2'd1: if (cnt == 0) begin req = "R7"; eUdf = 1'b1; end
              else begin req = "R3"; ePv = 1'b1; ePop = model[cnt-1]; cnt--; end
        default: if (cnt < 2) begin req = "R8"; eUdf = 1'b1; end
              else begin
                req = (op == 2'd2) ? "R4" : "R5";
                model[cnt-2] = expArith(op[0], model[cnt-1], model[cnt-2]);
                cnt--;
              end
      endcase
    end
    cmdValid = v; cmdOp = op; cmdData = d;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    check(req, "popValid", 32'(popValid), 32'(ePv));
    if (ePv) check(req, "popData", 32'(popData), 32'(ePop));
    check(req, "ovfErr", 32'(ovfErr), 32'(eOvf));
    check(req, "udfErr", 32'(udfErr), 32'(eUdf));
    check(req, "topData", 32'(topData), 32'(expTop()));
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "topData", 32'(topData), 32'd0);
    check("R1", "popValid", 32'(popValid), 32'd0);
    check("R1", "ovfErr", 32'(ovfErr), 32'd0);
    check("R1", "udfErr", 32'(udfErr), 32'd0);

    // R7 pop empty, R8 arith with 0 and 1 entries
    runCmd(1'b1, 2'd1, 16'd0);
    runCmd(1'b1, 2'd2, 16'd0);
    runCmd(1'b1, 2'd0, 16'h00AA);
    runCmd(1'b1, 2'd3, 16'd0);
    runCmd(1'b1, 2'd2, 16'd0);
    runCmd(1'b1, 2'd1, 16'd0);

    // R5 subtract wrap: top 1, beneath 5 -> 0xFFFC
    runCmd(1'b1, 2'd0, 16'd5);
    runCmd(1'b1, 2'd0, 16'd1);
    runCmd(1'b1, 2'd3, 16'd0);
    check("R5", "sub wrap", 32'(topData), 32'h0000FFFC);
    // R4 add wrap: 0xFFFC + 0x0007 -> 0x0003
    runCmd(1'b1, 2'd0, 16'd7);
    runCmd(1'b1, 2'd2, 16'd0);
    check("R4", "add wrap", 32'(topData), 32'h00000003);
    runCmd(1'b1, 2'd1, 16'd0);

    // R10 fill, R6 overflow, then drain in reverse
    for (int i = 0; i < DEPTH; i++) runCmd(1'b1, 2'd0, 16'(16'h1000 + i * 3));
    runCmd(1'b1, 2'd0, 16'hDEAD);
    runCmd(1'b0, 2'd1, 16'd0);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      runCmd(1'b1, 2'd1, 16'd0);
      check("R10", "lifo order", 32'(popData), 32'(16'h1000 + i * 3));
    end

    // random mix
    for (int n = 0; n < 800; n++) begin
      int r;
      logic [1:0] op;
      r = $urandom_range(0, 99);
      if (r < 42) op = 2'd0;
      else if (r < 74) op = 2'd1;
      else if (r < 85) op = 2'd2;
      else op = 2'd3;
      runCmd(($urandom_range(0, 9) != 0), op, 16'($urandom));
    end

    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule